// File: doc/BRIEF.md
# Programmable-Level Interrupt Controller

This block gathers sixteen level-sensitive interrupt inputs and turns them into one 3-bit interrupt priority level for a processor. Software gives each input its own level through a small byte-wide register bus. The output is the highest level among the inputs that are currently pending. A level of zero means that no interrupt is requested. Because the levels are programmed per input, the order between inputs is set by software and is not fixed by wiring.

A free-running divider inside the block produces a periodic tick of about 60 Hz at the default clock. Each tick makes input 10 pending and drives a one-cycle low strobe on a separate pin. Software drops that request by writing to an acknowledge location. Input 10 responds to edges: a rising input sets it, a falling input clears it. Every other input simply follows its pin.

Top module: `plirq_ctrl`

## Requirements
- R1: After reset the priority output is 0, the tick strobe is high, and every readable register returns 0x00.
- R2: A byte written to offsets 0x000 to 0x00F is stored as the level byte of the input with that index, and reads back unchanged.
- R3: Inputs 0 to 7 appear in bits 0 to 7 of offset 0x203, and inputs 8 to 15 in bits 0 to 7 of offset 0x202. For every input except 10, the bit equals the input as sampled at the previous clock edge.
- R4: The priority output is the largest low-3-bit level byte among pending inputs. It is registered, so it follows a change in pending state or in a level byte one clock later. Bits 7:3 of a level byte take no part.
- R5: A pending input whose level is 0 requests nothing; if it is the only one pending, the output stays 0.
- R6: Offset 0x200 reads 0x80 while the priority output is non-zero, and 0x00 otherwise.
- R7: A write to offset 0x207 clears the pending bit of input 10, even while that input is held high, and stores nothing; offset 0x207 reads 0x00.
- R8: Every TICK_DIV clocks the tick strobe goes low for exactly one cycle and input 10 becomes pending. A tick and an acknowledge write in the same cycle leave input 10 pending.
- R9: Offsets outside 0x000-0x00F, 0x200, 0x202, 0x203 read 0x00. Writes to them, including the pending offsets, change nothing.
- R10: Input 10 becomes pending on a rising edge of its pin and stops being pending on a falling edge. It does not become pending again while the pin stays high.
- R11: Read data appears on the read-data port one clock after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 16 | Level-sensitive interrupt inputs |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 10 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one clock after the strobe |
| ipl_o | output | 3 | Registered interrupt priority level |
| tick_n_o | output | 1 | One-cycle low strobe on each periodic tick |

## Verification
The hardest case to reach is an acknowledge write that lands in the same cycle as a periodic tick. The tick phase cannot be seen from the ports until a strobe appears, and the collision needs one exact clock edge. The bench first measures the full strobe period. It then waits for the next strobe and launches the acknowledge write from the same half-cycle in which it sees that strobe low. The write is therefore sampled at the edge where the tick sets input 10, and the bench checks that input 10 is still pending afterwards. Edge-versus-level behaviour is also covered: the acknowledge is issued while input 10 is held high, and the bench checks that the request does not come back until the pin falls and rises again.

// File: rtl/plirq_pkg.sv
package plirq_pkg;

    localparam int ADDR_W   = 10;
    localparam int DATA_W   = 8;
    localparam int LVL_W    = 3;
    localparam int NUM_SRC  = 16;
    localparam int TICK_SRC = 10;

    localparam logic [ADDR_W-1:0] OFF_STATUS  = 10'h200;
    localparam logic [ADDR_W-1:0] OFF_PEND_HI = 10'h202;
    localparam logic [ADDR_W-1:0] OFF_PEND_LO = 10'h203;
    localparam logic [ADDR_W-1:0] OFF_ACK     = 10'h207;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_LEVEL,
        REG_STATUS,
        REG_PEND_HI,
        REG_PEND_LO,
        REG_ACK
    } reg_kind_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    function automatic reg_kind_e reg_decode(input logic [ADDR_W-1:0] a);
        if (a < ADDR_W'(NUM_SRC))  return REG_LEVEL;
        if (a == OFF_STATUS)       return REG_STATUS;
        if (a == OFF_PEND_HI)      return REG_PEND_HI;
        if (a == OFF_PEND_LO)      return REG_PEND_LO;
        if (a == OFF_ACK)          return REG_ACK;
        return REG_NONE;
    endfunction

endpackage

// File: rtl/plirq_tick.sv
module plirq_tick #(
    parameter int DIV = 260469
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             tick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_q <= 1'b0;
        end
    end

    assign tick_o = tick_q;

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tick_q |=> !tick_q); // R8

endmodule

// File: rtl/plirq_regs.sv
module plirq_regs
    import plirq_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int LW    = LVL_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  bus_req_t                  req_i,
    input  logic [N_SRC-1:0]          src_i,
    input  logic                      tick_i,
    input  logic [LW-1:0]             ipl_i,
    output logic [N_SRC-1:0]          pend_o,
    output logic [N_SRC-1:0][LW-1:0]  lvl_o,
    output logic [DATA_W-1:0]         rdata_o
);
    localparam int IDX_W = $clog2(N_SRC);

    reg_kind_e                       kind;
    logic [IDX_W-1:0]                idx;
    logic                            ack;
    logic [N_SRC-1:0][DATA_W-1:0]    lvl_q;
    logic [N_SRC-1:0]                pend_w;
    logic [DATA_W-1:0]               rd_mux;
    logic [DATA_W-1:0]               rd_q;

    assign kind = reg_decode(req_i.addr);
    assign idx  = req_i.addr[IDX_W-1:0];
    assign ack  = req_i.wr && (kind == REG_ACK);

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
        end else if (req_i.wr && kind == REG_LEVEL) begin
            lvl_q[idx] <= req_i.data;
        end
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        logic pend_q;
        if (i == TICK_SRC) begin : g_edge
            logic src_d;
            always_ff @(posedge clk) begin
                if (rst) begin
                    src_d  <= 1'b0;
                    pend_q <= 1'b0;
                end else begin
                    src_d <= src_i[i];
                    if (tick_i || (src_i[i] && !src_d))
                        pend_q <= 1'b1;
                    else if (ack || (!src_i[i] && src_d))
                        pend_q <= 1'b0;
                end
            end
        end else begin : g_level
            always_ff @(posedge clk) begin
                if (rst) pend_q <= 1'b0;
                else     pend_q <= src_i[i];
            end
        end
        assign pend_w[i] = pend_q;
        assign lvl_o[i]  = lvl_q[i][LW-1:0];
    end

    always_comb begin
        case (kind)
            REG_LEVEL:   rd_mux = lvl_q[idx];
            REG_STATUS:  rd_mux = {(ipl_i != '0), {(DATA_W-1){1'b0}}};
            REG_PEND_HI: rd_mux = pend_w[2*DATA_W-1:DATA_W];
            REG_PEND_LO: rd_mux = pend_w[DATA_W-1:0];
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)           rd_q <= '0;
        else if (req_i.rd) rd_q <= rd_mux;
    end

    assign pend_o  = pend_w;
    assign rdata_o = rd_q;

    AST_LEVEL_STORE: assert property (@(posedge clk) disable iff (rst)
        (req_i.wr && kind == REG_LEVEL) |=> lvl_q[$past(idx)] == $past(req_i.data)); // R2
    AST_PEND_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        src_i[0] |=> pend_w[0]); // R3
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ack && !tick_i && !src_i[TICK_SRC]) |=> !pend_w[TICK_SRC]); // R7
    AST_TICK_SETS: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> pend_w[TICK_SRC]); // R8
    AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
        !req_i.rd |=> $stable(rd_q)); // R11

endmodule

// File: rtl/plirq_arbiter.sv
module plirq_arbiter #(
    parameter int N_SRC = 16,
    parameter int LW    = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_SRC-1:0]         pend_i,
    input  logic [N_SRC-1:0][LW-1:0] lvl_i,
    output logic [LW-1:0]            ipl_o
);
    logic [LW-1:0] best;
    logic [LW-1:0] ipl_q;

    always_comb begin
        best = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (pend_i[i] && (lvl_i[i] > best))
                best = lvl_i[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ipl_q <= '0;
        else     ipl_q <= best;
    end

    assign ipl_o = ipl_q;

    AST_IPL_IDLE: assert property (@(posedge clk) disable iff (rst)
        (pend_i == '0) |=> (ipl_q == '0)); // R5
    AST_IPL_COVERS: assert property (@(posedge clk) disable iff (rst)
        pend_i[0] |=> (ipl_q >= $past(lvl_i[0]))); // R4

endmodule

// File: rtl/plirq_ctrl.sv
module plirq_ctrl
    import plirq_pkg::*;
#(
    parameter int TICK_DIV = 260469
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  src_i,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [LVL_W-1:0]    ipl_o,
    output logic                tick_n_o
);
    bus_req_t                        req;
    logic                            tick;
    logic [NUM_SRC-1:0]              pend;
    logic [NUM_SRC-1:0][LVL_W-1:0]   lvl;
    logic [LVL_W-1:0]                ipl;

    assign req = '{wr: bus_wr, rd: bus_rd, addr: bus_addr, data: bus_wdata};

    plirq_tick #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    plirq_regs #(.N_SRC(NUM_SRC), .LW(LVL_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req),
        .src_i   (src_i),
        .tick_i  (tick),
        .ipl_i   (ipl),
        .pend_o  (pend),
        .lvl_o   (lvl),
        .rdata_o (bus_rdata)
    );

    plirq_arbiter #(.N_SRC(NUM_SRC), .LW(LVL_W)) u_arb (
        .clk    (clk),
        .rst    (rst),
        .pend_i (pend),
        .lvl_i  (lvl),
        .ipl_o  (ipl)
    );

    assign ipl_o    = ipl;
    assign tick_n_o = ~tick;

    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        !tick_n_o |=> tick_n_o); // R8

endmodule

// File: tb/plirq_ctrl_bench.sv
module plirq_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TDIV       = 2000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] src = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [9:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [2:0]  ipl;
    logic        tick_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct { string req; logic [9:0] a; logic [7:0] exp; } exp_t;
    exp_t q[$];
    logic rd_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    plirq_ctrl #(.TICK_DIV(TDIV)) u_plirq_ctrl (
        .clk(clk), .rst(rst), .src_i(src), .bus_wr(wr), .bus_rd(rd),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
        .ipl_o(ipl), .tick_n_o(tick_n)
    );

    // monitor: pop expected read results and compare
    always @(posedge clk) rd_seen <= rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (rdata !== e.exp) begin
                errors++;
                $display("FAIL %s read 0x%03h act 0x%02h exp 0x%02h", e.req, e.a, rdata, e.exp);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act %0d exp %0d", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [9:0] a, input logic [7:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bread(input logic [9:0] a, input logic [7:0] e, input string req);
        exp_t it;
        it.req = req; it.a = a; it.exp = e;
        q.push_back(it);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog act hung exp finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int cnt;
        repeat (4) @(negedge clk);
        chk("R1 strobe in reset", tick_n, 1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ipl after reset", ipl, 0);
        bread(10'h003, 8'h00, "R1");
        bread(10'h200, 8'h00, "R1");
        bread(10'h203, 8'h00, "R1");

        // level bytes
        bwrite(10'h005, 8'hA6);
        bwrite(10'h001, 8'h02);
        bwrite(10'h00C, 8'h03);
        bwrite(10'h00A, 8'h05);
        bwrite(10'h00F, 8'h00);
        bread(10'h005, 8'hA6, "R2 R11");
        bread(10'h00C, 8'h03, "R2");

        // single source
        src[1] = 1'b1; settle();
        chk("R4 ipl src1", ipl, 2);
        bread(10'h203, 8'h02, "R3");

        src[12] = 1'b1; settle();
        chk("R4 max of 2,3", ipl, 3);
        src[5] = 1'b1; settle();
        chk("R4 max low bits of 0xA6", ipl, 6);
        bread(10'h203, 8'h22, "R3");
        bread(10'h202, 8'h10, "R3");
        bread(10'h200, 8'h80, "R6");

        // upper level bits ignored
        bwrite(10'h005, 8'hF9); settle();
        chk("R4 upper bits ignored", ipl, 3);
        bread(10'h005, 8'hF9, "R2");

        // level zero source alone
        src[1] = 1'b0; src[5] = 1'b0; src[12] = 1'b0; src[15] = 1'b1; settle();
        chk("R5 level zero", ipl, 0);
        bread(10'h202, 8'h80, "R3");
        bread(10'h200, 8'h00, "R6");
        src[15] = 1'b0; settle();

        // edge-driven source 10 and acknowledge
        src[10] = 1'b1; settle();
        chk("R10 rise sets", ipl, 5);
        bread(10'h202, 8'h04, "R10");
        bwrite(10'h207, 8'hFF); settle();
        chk("R7 ack while high", ipl, 0);
        bread(10'h202, 8'h00, "R7");
        bread(10'h207, 8'h00, "R7");
        src[10] = 1'b0; settle();
        chk("R10 no re-request", ipl, 0);
        src[10] = 1'b1; settle();
        chk("R10 second rise", ipl, 5);
        src[10] = 1'b0; settle();
        chk("R10 fall clears", ipl, 0);

        // unmapped offsets
        bwrite(10'h123, 8'hFF);
        bread(10'h123, 8'h00, "R9");
        bread(10'h3FF, 8'h00, "R9");
        bwrite(10'h203, 8'hFF);
        bread(10'h203, 8'h00, "R9");
        bread(10'h00A, 8'h05, "R9 level intact");

        // periodic tick
        while (tick_n) @(negedge clk);
        @(negedge clk);
        chk("R8 strobe one cycle", tick_n, 1);
        cnt = 1;
        while (tick_n) begin @(negedge clk); cnt++; end
        chk("R8 period", cnt, TDIV);
        settle();
        chk("R8 tick sets src10", ipl, 5);
        bread(10'h202, 8'h04, "R8");
        bwrite(10'h207, 8'h00); settle();
        chk("R7 ack after tick", ipl, 0);

        // ack colliding with tick
        while (tick_n) @(negedge clk);
        bwrite(10'h207, 8'h00);
        settle();
        chk("R8 tick beats ack", ipl, 5);
        bread(10'h202, 8'h04, "R8");

        repeat (3) @(negedge clk);
        chk("R11 queue drained", q.size(), 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule